// File: doc/BRIEF.md
# Programmable Asynchronous Serial Line

This block is one full-duplex asynchronous serial channel. A set of static configuration inputs fixes the frame format: a 4-bit rate code, a 2-bit data-length code, a stop-length bit, a parity enable, a parity sense and a receiver enable. The transmitter and the receiver share a single 16x oversample tick, so both directions always run at the same rate. The tick comes from a divider, and the divider value for each rate code is computed at elaboration time from the `CLK_HZ` parameter.

The transmit path has two stages. A write lands in a holding register. That register moves into the active shifter when the previous frame ends, so back-to-back characters leave with no idle gap. A break input holds the serial output low. While break is set, the framing logic keeps running, so queued characters are still consumed and the holding register still frees up. The receiver synchronises the serial input and samples each bit at its middle. It rejects a false start bit and then delivers each character zero-extended to eight bits, with a parity-error flag and a framing-error flag. The parity bit never appears in either data word.

Top module: `serial_line`

## Requirements
- R1: The rate code selects 50, 75, 110, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200 or 9600 baud for codes 0 to 14. One bit lasts 16 oversample ticks. One tick lasts round(CLK_HZ*10 / (16 * rate*10)) clocks, with a minimum of 1. Code 15 produces no ticks, so a queued character is never sent.
- R2: The transmitter and the receiver use the same tick, so a looped-back line delivers the sent character at any rate code.
- R3: While the receiver-enable input is 0, the receiver stays idle and never asserts `rx_valid`.
- R4: Length code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. Data goes out least-significant bit first. Transmit data bits above the length are not sent, and received bits above the length read as zero.
- R5: With the stop-length bit at 0, the stop period is 1 bit. With it at 1, the stop period is 2 bits, or 1.5 bits when the length code is 0.
- R6: With parity enabled, one parity bit follows the data. For even sense (`cfg_par_odd`=0), the data bits plus the parity bit hold an even number of ones; for odd sense they hold an odd number. A received parity mismatch sets `rx_perr`. With parity disabled, no parity bit is sent or expected, and `rx_perr` stays 0.
- R7: A frame is a start bit at 0, the data bits, the optional parity bit and the stop period at 1. The line rests at 1, and after reset `txd` is 1.
- R8: While `brk` is 1, `txd` is held at 0. Characters written during break are still consumed, and `tx_ready` returns to 1.
- R9: `tx_ready` is 1 when the holding register is empty, and drops in the cycle after a write is accepted. A character in the holding register starts immediately after the current stop period, with no idle gap.
- R10: A low pulse on `rxd` that is high again at the middle of the start bit is rejected and produces no character.
- R11: A received stop sample of 0 sets `rx_ferr` alongside the character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rate | input | 4 | Rate code (0..14 valid, 15 halts the tick) |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_stop2 | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| cfg_rx_en | input | 1 | Receiver enable |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 8 | Character to transmit |
| tx_ready | output | 1 | Holding register empty |
| brk | input | 1 | Force the line to continuous zero |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_valid | output | 1 | One-cycle strobe: a character was received |
| rx_data | output | 8 | Received character, zero-extended |
| rx_perr | output | 1 | Parity error for the character in `rx_data` |
| rx_ferr | output | 1 | Framing error for the character in `rx_data` |

## Verification
The assertions assume that the configuration inputs change only while both directions are idle, and that `tx_wr` is pulsed only while `tx_ready` is 1. The bench changes the configuration only after the receiver has reported and the transmitter's stop period has run out, and it writes only after it has seen `tx_ready` high. The length check on received data relies on the length code staying fixed across a frame, which the stimulus holds to.

// File: rtl/sl_pkg.sv
package sl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } line_st_e;

   // rate in tenths of a baud for each code; 0 marks the unused code
   function automatic longint rate_x10(input int code);
      case (code)
         0:  return 500;
         1:  return 750;
         2:  return 1100;
         3:  return 1345;
         4:  return 1500;
         5:  return 3000;
         6:  return 6000;
         7:  return 12000;
         8:  return 18000;
         9:  return 20000;
         10: return 24000;
         11: return 36000;
         12: return 48000;
         13: return 72000;
         14: return 96000;
         default: return 0;
      endcase
   endfunction

   // clocks per oversample tick, rounded, at least 1; 0 for the unused code
   function automatic longint tick_div(input int code, input longint clk_hz);
      longint r;
      longint d;
      r = rate_x10(code);
      if (r == 0) return 0;
      d = (clk_hz * 10 + 8 * r) / (16 * r);
      if (d < 1) d = 1;
      return d;
   endfunction

endpackage

// File: rtl/sl_baud_gen.sv
module sl_baud_gen #(
   parameter longint CLK_HZ = 50_000_000,
   parameter int     DIV_W  = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] rate,
   output logic       tick
);
   localparam int NCODES = 16;

   logic [DIV_W-1:0] div_tab [NCODES];
   logic [DIV_W-1:0] cnt;
   logic [3:0]       last_rate;
   logic [DIV_W-1:0] cur_div;

   for (genvar g = 0; g < NCODES; g++) begin : g_tab
      assign div_tab[g] = DIV_W'(sl_pkg::tick_div(g, CLK_HZ));
   end

   assign cur_div = div_tab[rate];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         last_rate <= 4'd15;
      end else if (rate != last_rate || cur_div == '0) begin
         cnt       <= '0;
         last_rate <= rate;
      end else if (cnt == '0) begin
         cnt <= cur_div - 1'b1;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign tick = (cnt == '0) && (cur_div != '0) && (rate == last_rate);

   a_r1_unused_code_silent : assert property (@(posedge clk) disable iff (!rst_n)
      (rate == 4'd15) |-> !tick);

endmodule

// File: rtl/sl_tx.sv
module sl_tx
   import sl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] len,
   input  logic       stop2,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       brk,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic       ready,
   output logic       txd
);
   line_st_e   st;
   logic [5:0] sub;
   logic [2:0] bitn;
   logic [7:0] sh;
   logic       pbit;
   logic       hold_full;
   logic [7:0] hold;
   logic [7:0] mask;
   logic [2:0] last_bit;
   logic [5:0] stop_last;
   logic       line;

   assign mask      = 8'hFF >> (3 - len);
   assign last_bit  = 3'(len) + 3'd4;
   assign stop_last = !stop2 ? 6'd15 : (len == 2'd0 ? 6'd23 : 6'd31);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sub       <= '0;
         bitn      <= '0;
         sh        <= '0;
         pbit      <= 1'b0;
         hold_full <= 1'b0;
         hold      <= '0;
      end else begin
         if (wr && !hold_full) begin
            hold      <= wdata;
            hold_full <= 1'b1;
         end
         if (tick) begin
            case (st)
               ST_IDLE: if (hold_full) begin
                  sh        <= hold & mask;
                  pbit      <= (^(hold & mask)) ^ par_odd;
                  hold_full <= 1'b0;
                  sub       <= '0;
                  st        <= ST_START;
               end
               ST_START: if (sub == 6'd15) begin
                  sub  <= '0;
                  bitn <= '0;
                  st   <= ST_DATA;
               end else sub <= sub + 1'b1;
               ST_DATA: if (sub == 6'd15) begin
                  sub <= '0;
                  sh  <= sh >> 1;
                  if (bitn == last_bit) st <= par_en ? ST_PAR : ST_STOP;
                  else bitn <= bitn + 1'b1;
               end else sub <= sub + 1'b1;
               ST_PAR: if (sub == 6'd15) begin
                  sub <= '0;
                  st  <= ST_STOP;
               end else sub <= sub + 1'b1;
               ST_STOP: if (sub == stop_last) begin
                  sub <= '0;
                  if (hold_full) begin
                     sh        <= hold & mask;
                     pbit      <= (^(hold & mask)) ^ par_odd;
                     hold_full <= 1'b0;
                     st        <= ST_START;
                  end else st <= ST_IDLE;
               end else sub <= sub + 1'b1;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (st)
         ST_START: line = 1'b0;
         ST_DATA:  line = sh[0];
         ST_PAR:   line = pbit;
         default:  line = 1'b1;
      endcase
   end

   assign txd   = brk ? 1'b0 : line;
   assign ready = !hold_full;

   a_r9_write_fills_holding : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ready) |=> !ready);

   a_r5_stop_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP) |-> (sub <= 6'd31));

endmodule

// File: rtl/sl_rx.sv
module sl_rx
   import sl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] len,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       rx_en,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] data,
   output logic       perr,
   output logic       ferr
);
   logic       rxs;
   line_st_e   st;
   logic [3:0] cnt;
   logic [2:0] bitn;
   logic [7:0] sh;
   logic       pbit;
   logic [2:0] last_bit;
   logic [3:0] nbits;
   logic [7:0] aligned;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rxs = rxd;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= '1;
         else begin
            ff[0] <= rxd;
            for (int k = 1; k < SYNC_STAGES; k++) ff[k] <= ff[k-1];
         end
      end
      assign rxs = ff[SYNC_STAGES-1];
   end

   assign last_bit = 3'(len) + 3'd4;
   assign nbits    = 4'(len) + 4'd5;
   assign aligned  = sh >> (4'd8 - nbits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         sh    <= '0;
         pbit  <= 1'b0;
         valid <= 1'b0;
         data  <= '0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (!rx_en) begin
            st <= ST_IDLE;
         end else if (tick) begin
            case (st)
               ST_IDLE: if (!rxs) begin
                  cnt <= '0;
                  st  <= ST_START;
               end
               ST_START: if (cnt == 4'd7) begin
                  cnt  <= '0;
                  bitn <= '0;
                  st   <= rxs ? ST_IDLE : ST_DATA;
               end else cnt <= cnt + 1'b1;
               ST_DATA: if (cnt == 4'd15) begin
                  cnt <= '0;
                  sh  <= {rxs, sh[7:1]};
                  if (bitn == last_bit) st <= par_en ? ST_PAR : ST_STOP;
                  else bitn <= bitn + 1'b1;
               end else cnt <= cnt + 1'b1;
               ST_PAR: if (cnt == 4'd15) begin
                  cnt  <= '0;
                  pbit <= rxs;
                  st   <= ST_STOP;
               end else cnt <= cnt + 1'b1;
               ST_STOP: if (cnt == 4'd15) begin
                  cnt   <= '0;
                  st    <= ST_IDLE;
                  valid <= 1'b1;
                  data  <= aligned;
                  perr  <= par_en && (((^aligned) ^ par_odd) != pbit);
                  ferr  <= !rxs;
               end else cnt <= cnt + 1'b1;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   a_r3_disabled_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !valid);

   a_r4_upper_bits_zero : assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((data >> nbits) == 8'd0));

   a_r6_no_perr_without_parity : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !par_en) |-> !perr);

endmodule

// File: rtl/serial_line.sv
module serial_line #(
   parameter longint CLK_HZ      = 50_000_000,
   parameter int     SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] cfg_rate,
   input  logic [1:0] cfg_len,
   input  logic       cfg_stop2,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       cfg_rx_en,
   input  logic       tx_wr,
   input  logic [7:0] tx_data,
   output logic       tx_ready,
   input  logic       brk,
   output logic       txd,
   input  logic       rxd,
   output logic       rx_valid,
   output logic [7:0] rx_data,
   output logic       rx_perr,
   output logic       rx_ferr
);
   localparam longint MAX_DIV = sl_pkg::tick_div(0, CLK_HZ);
   localparam int     DIV_W   = $clog2(MAX_DIV + 1) + 1;

   if (CLK_HZ < 153_600) begin : g_bad_clk
      $error("serial_line: CLK_HZ too low for a 16x tick at the top rate");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("serial_line: SYNC_STAGES must be 0..4");
   end

   logic tick;

   sl_baud_gen #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .rate (cfg_rate),
      .tick (tick)
   );

   sl_tx u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .len    (cfg_len),
      .stop2  (cfg_stop2),
      .par_en (cfg_par_en),
      .par_odd(cfg_par_odd),
      .brk    (brk),
      .wr     (tx_wr),
      .wdata  (tx_data),
      .ready  (tx_ready),
      .txd    (txd)
   );

   sl_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .len    (cfg_len),
      .par_en (cfg_par_en),
      .par_odd(cfg_par_odd),
      .rx_en  (cfg_rx_en),
      .rxd    (rxd),
      .valid  (rx_valid),
      .data   (rx_data),
      .perr   (rx_perr),
      .ferr   (rx_ferr)
   );

   a_r8_break_holds_low : assert property (@(posedge clk) disable iff (!rst_n)
      (brk && $past(brk)) |-> !txd);

endmodule

// File: tb/tb_serial_line.sv
module tb_serial_line;
   localparam longint CLK_HZ = 153_600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] cfg_rate = 4'd14;
   logic [1:0] cfg_len = 2'd3;
   logic cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_rx_en = 1'b1;
   logic tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic brk = 1'b0;
   logic lb = 1'b1, drv = 1'b1;
   logic tx_ready, txd, rx_valid, rx_perr, rx_ferr;
   logic [7:0] rx_data;
   logic rxd;
   int tests = 0, fails = 0;

   assign rxd = lb ? txd : drv;

   always #10 clk = ~clk;

   serial_line #(.CLK_HZ(CLK_HZ)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_len(cfg_len),
      .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_rx_en(cfg_rx_en), .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready),
      .brk(brk), .txd(txd), .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr));

   function automatic longint exp_div(input int code);
      longint r10 [15] = '{500, 750, 1100, 1345, 1500, 3000, 6000, 12000,
                           18000, 20000, 24000, 36000, 48000, 72000, 96000};
      longint d;
      d = (CLK_HZ * 10 + 8 * r10[code]) / (16 * r10[code]);
      return (d < 1) ? 1 : d;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic send(input logic [7:0] d);
      while (!tx_ready) @(negedge clk);
      tx_data = d;
      tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic wait_rx(output bit got, output logic [7:0] d, output logic pe, output logic fe);
      got = 0; d = '0; pe = 0; fe = 0;
      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         if (rx_valid) begin
            got = 1; d = rx_data; pe = rx_perr; fe = rx_ferr;
            break;
         end
      end
   endtask

   task automatic drive_frame(input logic [11:0] bits, input int n);
      for (int i = 0; i < n; i++) begin
         drv = bits[i];
         repeat (16) @(negedge clk);
      end
      drv = 1'b1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      bit got;
      logic [7:0] d;
      logic pe, fe;
      int cnt;
      bit ok;
      logic [7:0] vals [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};

      repeat (3) @(negedge clk);
      // R7 R9: reset state
      check(txd == 1'b1, "R7 idle after reset", txd, 1);
      check(tx_ready == 1'b1, "R9 ready after reset", tx_ready, 1);
      check(rx_valid == 1'b0, "R3 no valid during reset", rx_valid, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R4 R6 R2: loopback sweep at the top rate
      for (int l = 0; l < 4; l++)
         for (int s = 0; s < 2; s++)
            for (int p = 0; p < 3; p++)
               for (int v = 0; v < 4; v++) begin
                  logic [7:0] m;
                  cfg_len = 2'(l); cfg_stop2 = s[0];
                  cfg_par_en = (p != 0); cfg_par_odd = (p == 2);
                  m = 8'hFF >> (3 - l);
                  send(vals[v] ^ 8'(l * 37 + p));
                  wait_rx(got, d, pe, fe);
                  check(got && d == ((vals[v] ^ 8'(l * 37 + p)) & m) && !pe && !fe,
                        "R4 R6 loopback char", d, (vals[v] ^ 8'(l * 37 + p)) & m);
                  repeat (48) @(negedge clk);
               end

      // R2: loopback at a slower code
      cfg_rate = 4'd11; cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_stop2 = 1'b0;
      repeat (10) @(negedge clk);
      send(8'h3C);
      wait_rx(got, d, pe, fe);
      check(got && d == 8'h3C && !pe, "R2 loopback at code 11", d, 8'h3C);
      repeat (100) @(negedge clk);
      cfg_rate = 4'd14; cfg_par_en = 1'b0;

      // R5 R9: stop period measured as the high gap between two zero frames
      for (int c = 0; c < 4; c++) begin
         int expv;
         cfg_len = (c < 2) ? 2'd0 : 2'd3;
         cfg_stop2 = c[0];
         expv = !c[0] ? 16 : (c < 2 ? 24 : 32);
         repeat (4) @(negedge clk);
         send(8'h00);
         send(8'h00);
         while (txd) @(negedge clk);
         while (!txd) @(negedge clk);
         cnt = 0;
         while (txd && cnt < 100) begin cnt++; @(negedge clk); end
         check(cnt == expv, "R5 R9 stop gap", cnt, expv);
         repeat (300) @(negedge clk);
      end

      // R6 R4: parity bit and bit order on the wire, 8 bits, data 0x07
      cfg_len = 2'd3; cfg_stop2 = 1'b0; cfg_par_en = 1'b1;
      for (int o = 0; o < 2; o++) begin
         logic b1, b4, bp;
         cfg_par_odd = o[0];
         repeat (4) @(negedge clk);
         send(8'h07);
         while (txd) @(negedge clk);
         repeat (8 + 16) @(negedge clk); b1 = txd;
         repeat (48) @(negedge clk); b4 = txd;
         repeat (80) @(negedge clk); bp = txd;
         check(b1 == 1'b1 && b4 == 1'b0, "R4 lsb first", {b1, b4}, 2'b10);
         check(bp == !o[0], "R6 parity bit on line", bp, !o[0]);
         repeat (100) @(negedge clk);
      end

      // R1: start+5 data zero bits last 96 ticks at each code
      cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
      for (int code = 0; code < 15; code++) begin
         longint dv;
         cfg_rate = 4'(code);
         dv = exp_div(code);
         repeat (4) @(negedge clk);
         send(8'h00);
         while (txd) @(negedge clk);
         cnt = 0;
         while (!txd) begin cnt++; @(negedge clk); end
         check(cnt == 96 * dv, "R1 bit time", cnt, 96 * dv);
         repeat (int'(24 * dv)) @(negedge clk);
      end

      // R1: code 15 sends nothing
      cfg_rate = 4'd15;
      repeat (4) @(negedge clk);
      send(8'h00);
      ok = 1;
      repeat (300) begin @(negedge clk); if (!txd) ok = 0; end
      check(ok && !tx_ready, "R1 unused code halts", {ok, tx_ready}, 2'b10);
      cfg_rate = 4'd14;
      repeat (300) @(negedge clk);

      // R3: receiver disabled
      cfg_rx_en = 1'b0; cfg_len = 2'd3;
      send(8'h55);
      ok = 1;
      repeat (400) begin @(negedge clk); if (rx_valid) ok = 0; end
      check(ok, "R3 no char while disabled", !ok, 0);
      cfg_rx_en = 1'b1;
      repeat (20) @(negedge clk);

      // R10: short low pulse rejected
      lb = 1'b0; drv = 1'b1;
      repeat (10) @(negedge clk);
      drv = 1'b0; repeat (4) @(negedge clk); drv = 1'b1;
      ok = 1;
      repeat (400) begin @(negedge clk); if (rx_valid) ok = 0; end
      check(ok, "R10 glitch rejected", !ok, 0);

      // R6: injected parity error, 8 bits even, data 0x07 sent with parity 0
      cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
      fork
         drive_frame({1'b1, 1'b0, 8'h07, 1'b0}, 11);
         wait_rx(got, d, pe, fe);
      join
      check(got && d == 8'h07 && pe && !fe, "R6 parity error flagged", {pe, d}, {1'b1, 8'h07});
      repeat (40) @(negedge clk);

      // R11: stop sampled low
      cfg_par_en = 1'b0;
      fork
         drive_frame({2'b00, 8'h81, 1'b0}, 10);
         wait_rx(got, d, pe, fe);
      join
      check(got && d == 8'h81 && fe && !pe, "R11 framing error flagged", {fe, d}, {1'b1, 8'h81});
      repeat (40) @(negedge clk);

      // R8: break holds low, characters still consumed
      brk = 1'b1;
      @(negedge clk);
      send(8'hFF);
      send(8'hFF);
      ok = 1;
      repeat (600) begin @(negedge clk); if (txd) ok = 0; end
      check(ok, "R8 line low during break", !ok, 0);
      check(tx_ready, "R8 characters consumed", tx_ready, 1);
      brk = 1'b0;
      @(negedge clk);
      check(txd, "R7 idle high after break", txd, 1);
      repeat (50) @(negedge clk);
      lb = 1'b1;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule